// File: doc/BRIEF.md
# Transmission Error Performance Monitor

This block grades each one-second interval of a received digital signal and accumulates long-term error statistics. Once per second a strobe delivers two facts about the interval that just ended: how many of its blocks were found errored, and whether a defect was seen at any point in it. From these the block decides whether the second was errored and whether it was severely errored. It then keeps five saturating tallies: errored seconds, severely errored seconds, background block errors, unavailable seconds and short-burst events (runs of two to nine severe seconds).

Availability is decided over runs of ten seconds. Both the start and the end of unavailable time are dated back to the first second of the run that caused the change. Each graded second therefore waits in a ten-deep delay line until its availability can no longer change. Only then is it added to the tallies. The tallies trail the live signal by exactly ten seconds. A separate output shows the live availability state without that delay. A synchronous clear wipes the tallies, the delay line and the availability state.

Top module: `pm_perf_mon`

## Requirements
- R1: A second is errored when its errored-block count is at least one, or when it is severely errored.
- R2: A second is severely errored when the defect input is high at its strobe, or when errored blocks × 10 ≥ BLOCKS_PER_SEC × 3. With 20 blocks per second, 6 errored blocks is severe and 5 is not.
- R3: Errored blocks are added to the background tally only for seconds that are available and not severely errored.
- R4: Ten consecutive severe seconds make all ten of them unavailable. They add to the unavailable tally only, and not to the errored, severe or background tallies.
- R5: During unavailable time, ten consecutive non-severe seconds make all ten of them available again, and they are counted as ordinary available seconds.
- R6: The short-burst tally rises by one when a run of 2 to 9 severe available seconds is ended by a non-severe available second. A single severe second, or a run that grows to ten, does not count.
- R7: A second delivered at strobe k changes the tallies at strobe k+10 and not before.
- R8: Every tally stops at its all-ones value and never wraps around.
- R9: The clear input zeroes all tallies, empties the delay line and returns the block to the available state. No second delivered before the clear is ever counted.
- R10: Between strobes, the tallies and the availability output do not change, whatever the data inputs do.
- R11: The `unavail` output goes high on the strobe of the tenth consecutive severe second. It goes low on the strobe of the tenth consecutive non-severe second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of tallies, delay line and state |
| sec_tick | input | 1 | One-cycle strobe closing a one-second interval |
| blk_errs | input | BLK_W | Errored blocks in the closing second (0..BLOCKS_PER_SEC) |
| defect | input | 1 | A defect was present in the closing second |
| es_count | output | CNT_W | Errored seconds |
| ses_count | output | CNT_W | Severely errored seconds |
| bbe_count | output | CNT_W | Background block errors |
| uas_count | output | CNT_W | Unavailable seconds |
| cses_count | output | CNT_W | Runs of 2 to 9 severe seconds |
| unavail | output | 1 | Live availability state (high = unavailable) |

## Verification
The assertions rely on a few assumptions about the inputs. `sec_tick` is a single-cycle pulse. `blk_errs` never exceeds the configured number of blocks per second. `clr` is treated as a synchronous event that may arrive on any cycle, including a strobe cycle. The stimulus meets these assumptions by construction: each second is applied through one task that raises the strobe for exactly one cycle, block counts are chosen between 0 and 20 for a 20-block second, and data inputs are changed freely only on cycles where the strobe is low. The tallies are narrowed to 8 bits so that saturation can be reached within a short run.

// File: rtl/pm_pkg.sv
package pm_pkg;

  // Severity ratio test: errored share of the second is 30 % or more.
  function automatic logic ratio_severe(input longint unsigned errs,
                                        input longint unsigned total);
    return (errs * 64'd10) >= (total * 64'd3);
  endfunction

  // Grade flags carried by each second through the delay line.
  typedef struct packed {
    logic ua;
    logic es;
    logic ses;
  } pm_grade_t;

endpackage

// File: rtl/pm_sec_class.sv
module pm_sec_class #(
  parameter int BLOCKS_PER_SEC = 8000,
  parameter int BLK_W          = 13
) (
  input  logic [BLK_W-1:0] blk_errs,
  input  logic             defect,
  output logic             sec_es,
  output logic             sec_ses
);
  logic ratio_hit;

  assign ratio_hit = pm_pkg::ratio_severe(64'(blk_errs), 64'(BLOCKS_PER_SEC));
  assign sec_ses   = defect | ratio_hit;
  assign sec_es    = sec_ses | (blk_errs != '0);

  always_comb begin
    if (sec_ses && !defect)
      a_r2_ratio_nonzero: assert (blk_errs != '0 || BLOCKS_PER_SEC == 0);
  end
endmodule

// File: rtl/pm_avail_track.sv
module pm_avail_track #(
  parameter int RUN_LEN = 10,
  parameter int BLK_W   = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic             in_es,
  input  logic             in_ses,
  input  logic [BLK_W-1:0] in_cnt,
  output logic             out_valid,
  output pm_pkg::pm_grade_t out_grade,
  output logic [BLK_W-1:0] out_cnt,
  output logic             unavail
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam logic [RUN_W-1:0] LAST = RUN_W'(RUN_LEN - 1);
  localparam logic [RUN_W-1:0] FULL = RUN_W'(RUN_LEN);

  logic [RUN_LEN-1:0] v_q, ua_q, es_q, ses_q;
  logic [BLK_W-1:0]   cnt_q [RUN_LEN];
  logic [RUN_W-1:0]   sev_run, ok_run;
  logic               cur_ua;
  logic               enter_ua, leave_ua;

  // Named state-change events used by the delay line and the assertions.
  assign enter_ua = tick && !clr && !cur_ua &&  in_ses && (sev_run == LAST);
  assign leave_ua = tick && !clr &&  cur_ua && !in_ses && (ok_run  == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sev_run <= '0;
      ok_run  <= '0;
      cur_ua  <= 1'b0;
    end else if (clr) begin
      sev_run <= '0;
      ok_run  <= '0;
      cur_ua  <= 1'b0;
    end else if (tick) begin
      if (in_ses) begin
        sev_run <= (sev_run == FULL) ? FULL : sev_run + 1'b1;
        ok_run  <= '0;
      end else begin
        ok_run  <= (ok_run == FULL) ? FULL : ok_run + 1'b1;
        sev_run <= '0;
      end
      if (enter_ua)      cur_ua <= 1'b1;
      else if (leave_ua) cur_ua <= 1'b0;
    end
  end

  // Delay line: stage 0 takes the new second, the last stage leaves for commit.
  // A state change rewrites the availability flag of the whole ten-second window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0; ua_q <= '0; es_q <= '0; ses_q <= '0;
      for (int i = 0; i < RUN_LEN; i++) cnt_q[i] <= '0;
    end else if (clr) begin
      v_q <= '0; ua_q <= '0; es_q <= '0; ses_q <= '0;
      for (int i = 0; i < RUN_LEN; i++) cnt_q[i] <= '0;
    end else if (tick) begin
      for (int i = RUN_LEN - 1; i > 0; i--) begin
        v_q[i]   <= v_q[i-1];
        es_q[i]  <= es_q[i-1];
        ses_q[i] <= ses_q[i-1];
        cnt_q[i] <= cnt_q[i-1];
        ua_q[i]  <= enter_ua ? 1'b1 : (leave_ua ? 1'b0 : ua_q[i-1]);
      end
      v_q[0]   <= 1'b1;
      es_q[0]  <= in_es;
      ses_q[0] <= in_ses;
      cnt_q[0] <= in_cnt;
      ua_q[0]  <= enter_ua ? 1'b1 : (leave_ua ? 1'b0 : cur_ua);
    end
  end

  assign out_valid     = tick && !clr && v_q[RUN_LEN-1];
  assign out_grade.ua  = ua_q[RUN_LEN-1];
  assign out_grade.es  = es_q[RUN_LEN-1];
  assign out_grade.ses = ses_q[RUN_LEN-1];
  assign out_cnt       = cnt_q[RUN_LEN-1];
  assign unavail       = cur_ua;

  // R4: after entering, every second in the window is marked unavailable.
  a_r4_window_marked: assert property (@(posedge clk) disable iff (!rst_n)
    enter_ua |=> (unavail && (&ua_q)));
  // R5: after leaving, every second in the window is marked available.
  a_r5_window_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    leave_ua |=> (!unavail && (ua_q == '0)));
  // R9: clear empties the line and restores availability.
  a_r9_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (v_q == '0 && !unavail));
  // R10: no strobe, no movement.
  a_r10_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> ($stable(v_q) && $stable(ua_q) && $stable(unavail)));
endmodule

// File: rtl/pm_sat_ctr.sv
module pm_sat_ctr #(
  parameter int CNT_W = 32,
  parameter int INC_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] q
);
  logic [CNT_W:0] sum;

  assign sum = {1'b0, q} + (CNT_W+1)'(inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (clr)   q <= '0;
    else if (en)    q <= sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
  end

  // R8: a tally never goes down except through clear.
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (q >= $past(q)));
  // R10: a tally only moves on a commit.
  a_r10_ctr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(q));
endmodule

// File: rtl/pm_tally.sv
module pm_tally #(
  parameter int CNT_W   = 32,
  parameter int BLK_W   = 13,
  parameter int RUN_LEN = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              c_valid,
  input  pm_pkg::pm_grade_t c_grade,
  input  logic [BLK_W-1:0]  c_cnt,
  output logic [CNT_W-1:0]  es_count,
  output logic [CNT_W-1:0]  ses_count,
  output logic [CNT_W-1:0]  bbe_count,
  output logic [CNT_W-1:0]  uas_count,
  output logic [CNT_W-1:0]  cses_count
);
  localparam int NCTR  = 5;
  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam logic [RUN_W-1:0] LAST = RUN_W'(RUN_LEN - 1);
  localparam logic [RUN_W-1:0] FULL = RUN_W'(RUN_LEN);

  logic [RUN_W-1:0]           burst_run;
  logic                       avail_commit, ua_commit, burst_hit;
  logic [NCTR-1:0]            ctr_en;
  logic [NCTR-1:0][BLK_W-1:0] ctr_inc;
  logic [NCTR-1:0][CNT_W-1:0] ctr_q;

  assign avail_commit = c_valid && !c_grade.ua;
  assign ua_commit    = c_valid &&  c_grade.ua;
  assign burst_hit    = avail_commit && !c_grade.ses &&
                        (burst_run >= RUN_W'(2)) && (burst_run <= LAST);

  // Length of the current run of severe available seconds on the commit side.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   burst_run <= '0;
    else if (clr) burst_run <= '0;
    else if (c_valid) begin
      if (c_grade.ua || !c_grade.ses) burst_run <= '0;
      else burst_run <= (burst_run == FULL) ? FULL : burst_run + 1'b1;
    end
  end

  assign ctr_en[0]  = avail_commit && c_grade.es;
  assign ctr_en[1]  = avail_commit && c_grade.ses;
  assign ctr_en[2]  = avail_commit && !c_grade.ses;
  assign ctr_en[3]  = ua_commit;
  assign ctr_en[4]  = burst_hit;
  assign ctr_inc[0] = BLK_W'(1);
  assign ctr_inc[1] = BLK_W'(1);
  assign ctr_inc[2] = c_cnt;
  assign ctr_inc[3] = BLK_W'(1);
  assign ctr_inc[4] = BLK_W'(1);

  for (genvar k = 0; k < NCTR; k++) begin : g_ctr
    pm_sat_ctr #(.CNT_W(CNT_W), .INC_W(BLK_W)) u_ctr (
      .clk (clk),
      .rst_n (rst_n),
      .clr (clr),
      .en  (ctr_en[k]),
      .inc (ctr_inc[k]),
      .q   (ctr_q[k])
    );
  end

  assign es_count   = ctr_q[0];
  assign ses_count  = ctr_q[1];
  assign bbe_count  = ctr_q[2];
  assign uas_count  = ctr_q[3];
  assign cses_count = ctr_q[4];

  // R3: a severe second leaves the background tally alone.
  a_r3_no_bbe_on_severe: assert property (@(posedge clk) disable iff (!rst_n)
    (c_valid && c_grade.ses && !clr) |=> $stable(bbe_count));
  // R4: unavailable seconds touch only the unavailable tally.
  a_r4_quiet_when_ua: assert property (@(posedge clk) disable iff (!rst_n)
    (ua_commit && !clr) |=> ($stable(es_count) && $stable(ses_count) &&
                            $stable(bbe_count) && $stable(cses_count)));
  // R1: a severe second is always also an errored second.
  a_r1_ses_implies_es: assert property (@(posedge clk) disable iff (!rst_n)
    (c_valid && c_grade.ses) |-> c_grade.es);
  // R6: a burst never outgrows the availability window on the commit side.
  a_r6_burst_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    burst_run <= LAST);
endmodule

// File: rtl/pm_perf_mon.sv
module pm_perf_mon #(
  parameter int BLOCKS_PER_SEC = 8000,
  parameter int CNT_W          = 32,
  parameter int RUN_LEN        = 10,
  localparam int BLK_W         = $clog2(BLOCKS_PER_SEC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             sec_tick,
  input  logic [BLK_W-1:0] blk_errs,
  input  logic             defect,
  output logic [CNT_W-1:0] es_count,
  output logic [CNT_W-1:0] ses_count,
  output logic [CNT_W-1:0] bbe_count,
  output logic [CNT_W-1:0] uas_count,
  output logic [CNT_W-1:0] cses_count,
  output logic             unavail
);
  logic              sec_es, sec_ses;
  logic              cm_valid;
  pm_pkg::pm_grade_t cm_grade;
  logic [BLK_W-1:0]  cm_cnt;

  pm_sec_class #(.BLOCKS_PER_SEC(BLOCKS_PER_SEC), .BLK_W(BLK_W)) u_class (
    .blk_errs (blk_errs),
    .defect   (defect),
    .sec_es   (sec_es),
    .sec_ses  (sec_ses)
  );

  pm_avail_track #(.RUN_LEN(RUN_LEN), .BLK_W(BLK_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .tick      (sec_tick),
    .in_es     (sec_es),
    .in_ses    (sec_ses),
    .in_cnt    (blk_errs),
    .out_valid (cm_valid),
    .out_grade (cm_grade),
    .out_cnt   (cm_cnt),
    .unavail   (unavail)
  );

  pm_tally #(.CNT_W(CNT_W), .BLK_W(BLK_W), .RUN_LEN(RUN_LEN)) u_tally (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .c_valid    (cm_valid),
    .c_grade    (cm_grade),
    .c_cnt      (cm_cnt),
    .es_count   (es_count),
    .ses_count  (ses_count),
    .bbe_count  (bbe_count),
    .uas_count  (uas_count),
    .cses_count (cses_count)
  );

  // R7: nothing is committed unless a strobe is present.
  a_r7_commit_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |-> sec_tick);
endmodule

// File: tb/pm_perf_mon_tb.sv
module pm_perf_mon_tb;
  localparam int BPS   = 20;
  localparam int CW    = 8;
  localparam int BW    = $clog2(BPS + 1);
  localparam int CMAX  = (1 << CW) - 1;
  localparam int HMAX  = 512;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr = 1'b0;
  logic          sec_tick = 1'b0;
  logic [BW-1:0] blk_errs = '0;
  logic          defect = 1'b0;
  logic [CW-1:0] es_count, ses_count, bbe_count, uas_count, cses_count;
  logic          unavail;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int hist_cnt [HMAX];
  bit hist_def [HMAX];
  int nsec = 0;

  int e_es, e_ses, e_bbe, e_uas, e_cses;
  bit e_ua;

  always #10 clk = ~clk;

  pm_perf_mon #(.BLOCKS_PER_SEC(BPS), .CNT_W(CW)) u_dut (
    .clk (clk), .rst_n (rst_n), .clr (clr), .sec_tick (sec_tick),
    .blk_errs (blk_errs), .defect (defect),
    .es_count (es_count), .ses_count (ses_count), .bbe_count (bbe_count),
    .uas_count (uas_count), .cses_count (cses_count), .unavail (unavail)
  );

  function automatic int cap(input int x);
    return (x > CMAX) ? CMAX : x;
  endfunction

  // Reference model built straight from the requirements, over the whole history.
  task automatic model();
    int ua [HMAX];
    bit sev [HMAX];
    int state = 0, srun = 0, orun = 0, burst = 0;
    int es = 0, ses = 0, bbe = 0, uas = 0, cs = 0;
    for (int i = 0; i < nsec; i++) begin
      sev[i] = hist_def[i] || (hist_cnt[i] * 100 >= BPS * 30);   // R2
      if (sev[i]) begin srun++; orun = 0; end else begin orun++; srun = 0; end
      ua[i] = state;
      if (state == 0 && srun >= 10) begin
        for (int j = i - 9; j <= i; j++) ua[j] = 1;
        state = 1;
      end else if (state == 1 && orun >= 10) begin
        for (int j = i - 9; j <= i; j++) ua[j] = 0;
        state = 0;
      end
    end
    for (int i = 0; i < nsec - 10; i++) begin
      if (ua[i] != 0) begin uas++; burst = 0; end
      else begin
        if (sev[i] || hist_cnt[i] > 0) es++;
        if (sev[i]) begin ses++; burst++; end
        else begin
          bbe += hist_cnt[i];
          if (burst >= 2 && burst <= 9) cs++;
          burst = 0;
        end
      end
    end
    e_es = cap(es); e_ses = cap(ses); e_bbe = cap(bbe);
    e_uas = cap(uas); e_cses = cap(cs); e_ua = (state != 0);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    model();
    chk(req, "es_count",   int'(es_count),   e_es);
    chk(req, "ses_count",  int'(ses_count),  e_ses);
    chk(req, "bbe_count",  int'(bbe_count),  e_bbe);
    chk(req, "uas_count",  int'(uas_count),  e_uas);
    chk(req, "cses_count", int'(cses_count), e_cses);
    chk(req, "unavail",    int'(unavail),    int'(e_ua));
  endtask

  task automatic one_sec(input int c, input bit d);
    @(negedge clk);
    blk_errs = BW'(c);
    defect   = d;
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    blk_errs = '0;
    defect   = 1'b0;
    if (nsec < HMAX) begin
      hist_cnt[nsec] = c;
      hist_def[nsec] = d;
      nsec++;
    end
  endtask

  task automatic secs(input int num, input int c, input bit d);
    for (int i = 0; i < num; i++) one_sec(c, d);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    nsec = 0;
  endtask

  task automatic t_reset();
    compare_all("R9 reset");
  endtask

  // R1, R3, R7: errored seconds and background blocks, with the ten-second lag.
  task automatic t_basic();
    do_clear();
    one_sec(3, 0);
    secs(9, 0, 0);
    compare_all("R7 before commit");
    chk("R7", "bbe still zero at tick 9", int'(bbe_count), 0);
    one_sec(0, 0);
    compare_all("R7 at commit");
    chk("R3", "bbe after commit", int'(bbe_count), 3);
    one_sec(5, 0); one_sec(1, 0); one_sec(0, 0);
    secs(10, 0, 0);
    compare_all("R1 R3 mixed");
    chk("R1", "errored seconds", int'(es_count), 3);
  endtask

  // R2: ratio boundary and defect-only severity.
  task automatic t_severity();
    do_clear();
    one_sec(5, 0); one_sec(0, 0);
    one_sec(6, 0); one_sec(0, 0);
    one_sec(0, 1); one_sec(0, 0);
    one_sec(20, 0); one_sec(0, 0);
    secs(10, 0, 0);
    compare_all("R2 boundary");
    chk("R2", "severe seconds", int'(ses_count), 3);
    chk("R2", "background only from the 5", int'(bbe_count), 5);
  endtask

  // R6: bursts of 1, 2 and 9 severe seconds.
  task automatic t_bursts();
    do_clear();
    one_sec(0, 1); one_sec(0, 0);
    secs(2, 0, 1); one_sec(0, 0);
    secs(9, 0, 1); one_sec(0, 0);
    secs(10, 0, 0);
    compare_all("R6 bursts");
    chk("R6", "burst events", int'(cses_count), 2);
  endtask

  // R4, R5, R11: entry and exit of unavailable time.
  task automatic t_unavail();
    do_clear();
    secs(2, 2, 0);
    secs(9, 0, 1);
    chk("R11", "still available after 9", int'(unavail), 0);
    one_sec(0, 1);
    chk("R11", "unavailable on tenth", int'(unavail), 1);
    secs(2, 7, 0);
    secs(9, 4, 0);
    chk("R11", "still unavailable after 9 clean", int'(unavail), 1);
    one_sec(4, 0);
    chk("R11", "available on tenth clean", int'(unavail), 0);
    secs(10, 0, 0);
    compare_all("R4 R5 window");
    chk("R4", "unavailable seconds", int'(uas_count), 12);
    chk("R5", "background from recovery run", int'(bbe_count), 4 + 40);
  endtask

  // R10: inputs wiggle with no strobe.
  task automatic t_hold();
    do_clear();
    secs(12, 2, 0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      blk_errs = BW'(i % 21);
      defect   = i[0];
    end
    @(negedge clk);
    blk_errs = '0; defect = 1'b0;
    compare_all("R10 hold");
  endtask

  // R8: background tally pinned at all ones.
  task automatic t_saturate();
    do_clear();
    secs(60, 5, 0);
    secs(10, 0, 0);
    compare_all("R8 saturate");
    chk("R8", "bbe pinned", int'(bbe_count), CMAX);
  endtask

  // R9: clear in unavailable time forgets everything.
  task automatic t_clear();
    do_clear();
    secs(12, 0, 1);
    chk("R9", "unavailable before clear", int'(unavail), 1);
    do_clear();
    compare_all("R9 after clear");
    secs(10, 0, 0);
    compare_all("R9 no leftovers");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_severity();
    t_bursts();
    t_unavail();
    t_hold();
    t_saturate();
    t_clear();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule